// File: doc/BRIEF.md
# PCI Configuration Status Register

This block holds the 16-bit status word that one PCI function returns from configuration offset 06h. The bus interface logic sends it single-cycle event pulses. These report detected parity errors, system errors the function has signalled, aborts seen on cycles the function started as master, and target aborts the function issued. The block latches each event in a sticky bit that stays set until a configuration write clears it. A write clears a bit by putting 1 in that bit position. A 0 in a bit position leaves that bit alone.

Some events only count when an enable from the command register is set. A system error only latches when SERR reporting is enabled. The data-parity flag only latches when three things hold together: PERR is observed, the function is bus master, and parity-error response is enabled. The remaining bits are read-only. They carry a fixed medium DEVSEL timing code, a capabilities-list flag, zeros for unsupported features, and an interrupt-status bit. The interrupt-status bit mirrors the function's pending interrupt. The interrupt-disable bit of the command register gates that status onto the active-low INTx pin.

Top module: `pci_cfg_status`

## Requirements
- R1: While reset is applied and in the first cycle after it, the read data is 0210h and INTx is deasserted (high).
- R2: A parity-error pulse (address or data) sets bit 15, and the bit is visible in the cycle after the pulse.
- R3: A system-error pulse sets bit 14 only when the SERR enable input is 1. With the enable at 0 the bit stays 0.
- R4: A master-abort-received pulse sets bit 13. A target-abort-received pulse sets bit 12. A target-abort-signalled pulse sets bit 11. Each pulse sets only its own bit.
- R5: Bit 8 sets only in a cycle where PERR is seen, bus-master is active and the parity-response enable is 1, all three together. Any of the other seven combinations leaves it 0.
- R6: A configuration write clears each sticky bit (15, 14, 13, 12, 11, 8) whose write-data bit is 1, and leaves every sticky bit whose write-data bit is 0 unchanged.
- R7: If a set event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R8: Bits 10:9 always read 01b, bits 7:5 and 2:0 always read 0, and bit 4 always reads 1, including after a write of FFFFh.
- R9: Bit 3 equals the interrupt-pending input registered one cycle earlier. The interrupt-disable input has no effect on it.
- R10: INTx (active low) is 0 exactly when bit 3 is 1 and the interrupt-disable input is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| parityErrEvt | input | 1 | Pulse: address or data parity error detected |
| sysErrEvt | input | 1 | Pulse: function signalled a system error |
| serrEnable | input | 1 | Command register SERR enable |
| masterAbortEvt | input | 1 | Pulse: own master cycle ended in master abort |
| targetAbortRcvEvt | input | 1 | Pulse: own master cycle ended in target abort |
| targetAbortSigEvt | input | 1 | Pulse: function ended a transaction with target abort |
| perrSeen | input | 1 | PERR observed from any device |
| busMasterActive | input | 1 | Function is bus master for the current data phase |
| parityRespEnable | input | 1 | Command register parity-error response enable |
| intDisable | input | 1 | Command register interrupt disable |
| intPending | input | 1 | Valid, enabled interrupt condition is pending |
| wrEn | input | 1 | Configuration write to this register |
| wrData | input | 16 | Configuration write data |
| rdData | output | 16 | Register read value |
| intxN | output | 1 | Active-low INTx pin |

## Verification
The write-1-to-clear path is swept over all 64 masks of the six sticky bits, each applied with every bit set beforehand. This separates a wrong bit position from a clear that spills into neighbouring bits or a write of 0 that wrongly clears. The gated flags are driven through every combination of their qualifiers: all eight for the data-parity flag and all four for the system-error flag. That shows the AND terms are neither missing nor swapped. Each abort and parity pulse is applied alone so the bit it sets can be told apart from the others. Same-cycle set and clear, a write of FFFFh against the read-only fields, and all four pending/disable combinations for interrupt status and INTx cover the remaining corner cases.

// File: rtl/pci_cfg_status_pkg.sv
package pci_cfg_status_pkg;
  localparam int REG_W    = 16;
  localparam int STICKY_N = 6;
  // fixed read value of the read-only fields: DEVSEL timing 01b, capability list 1
  localparam logic [REG_W-1:0] CONST_VAL = 16'h0210;
  localparam int INT_BIT = 3;

  // sticky index -> bit position: 0 is data parity (bit 8), 1..5 map to bits 11..15
  function automatic int stickyPos(input int idx);
    return (idx == 0) ? 8 : 10 + idx;
  endfunction

  typedef struct packed {
    logic parity;     // idx 5
    logic sysErr;     // idx 4
    logic mAbort;     // idx 3
    logic tAbortRcv;  // idx 2
    logic tAbortSig;  // idx 1
    logic dataPar;    // idx 0
  } stickyEvt_t;

  typedef struct packed {
    stickyEvt_t setEvt;
    stickyEvt_t clrEvt;
    logic       intSample;
  } strobes_t;
endpackage

// File: rtl/pci_cfg_status_ctrl.sv
module pci_cfg_status_ctrl
  import pci_cfg_status_pkg::*;
(
  input  logic             parityErrEvt,
  input  logic             sysErrEvt,
  input  logic             serrEnable,
  input  logic             masterAbortEvt,
  input  logic             targetAbortRcvEvt,
  input  logic             targetAbortSigEvt,
  input  logic             perrSeen,
  input  logic             busMasterActive,
  input  logic             parityRespEnable,
  input  logic             intPending,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output strobes_t         strobes
);
  logic [STICKY_N-1:0] clrVec;

  // write-1-to-clear mask gathered from the sticky positions
  always_comb begin
    for (int i = 0; i < STICKY_N; i++) begin
      clrVec[i] = wrEn & wrData[stickyPos(i)];
    end
  end

  always_comb begin
    strobes.setEvt.parity    = parityErrEvt;
    strobes.setEvt.sysErr    = sysErrEvt & serrEnable;
    strobes.setEvt.mAbort    = masterAbortEvt;
    strobes.setEvt.tAbortRcv = targetAbortRcvEvt;
    strobes.setEvt.tAbortSig = targetAbortSigEvt;
    strobes.setEvt.dataPar   = perrSeen & busMasterActive & parityRespEnable;
    strobes.clrEvt           = stickyEvt_t'(clrVec);
    strobes.intSample        = intPending;
  end
endmodule

// File: rtl/pci_cfg_status_dp.sv
module pci_cfg_status_dp
  import pci_cfg_status_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strobes,
  output logic [REG_W-1:0] rdData,
  output logic             intStatus
);
  logic [STICKY_N-1:0] stickyQ;
  logic [STICKY_N-1:0] setVec;
  logic [STICKY_N-1:0] clrVec;

  assign setVec = strobes.setEvt;
  assign clrVec = strobes.clrEvt;

  // set has priority over a same-cycle clear
  for (genvar g = 0; g < STICKY_N; g++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (!rstN) stickyQ[g] <= 1'b0;
      else       stickyQ[g] <= setVec[g] | (stickyQ[g] & ~clrVec[g]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) intStatus <= 1'b0;
    else       intStatus <= strobes.intSample;
  end

  always_comb begin
    rdData = CONST_VAL;
    for (int i = 0; i < STICKY_N; i++) begin
      rdData[stickyPos(i)] = stickyQ[i];
    end
    rdData[INT_BIT] = intStatus;
  end
endmodule

// File: rtl/pci_cfg_status.sv
module pci_cfg_status
  import pci_cfg_status_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             parityErrEvt,
  input  logic             sysErrEvt,
  input  logic             serrEnable,
  input  logic             masterAbortEvt,
  input  logic             targetAbortRcvEvt,
  input  logic             targetAbortSigEvt,
  input  logic             perrSeen,
  input  logic             busMasterActive,
  input  logic             parityRespEnable,
  input  logic             intDisable,
  input  logic             intPending,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             intxN
);
  strobes_t strobes;
  logic     intStatus;

  pci_cfg_status_ctrl u_ctrl (
    .parityErrEvt      (parityErrEvt),
    .sysErrEvt         (sysErrEvt),
    .serrEnable        (serrEnable),
    .masterAbortEvt    (masterAbortEvt),
    .targetAbortRcvEvt (targetAbortRcvEvt),
    .targetAbortSigEvt (targetAbortSigEvt),
    .perrSeen          (perrSeen),
    .busMasterActive   (busMasterActive),
    .parityRespEnable  (parityRespEnable),
    .intPending        (intPending),
    .wrEn              (wrEn),
    .wrData            (wrData),
    .strobes           (strobes)
  );

  pci_cfg_status_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .rdData    (rdData),
    .intStatus (intStatus)
  );

  assign intxN = ~(intStatus & ~intDisable);
endmodule

// File: rtl/pci_cfg_status_chk.sv
module pci_cfg_status_chk
  import pci_cfg_status_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             parityErrEvt,
  input logic             sysErrEvt,
  input logic             serrEnable,
  input logic             masterAbortEvt,
  input logic             targetAbortRcvEvt,
  input logic             targetAbortSigEvt,
  input logic             perrSeen,
  input logic             busMasterActive,
  input logic             parityRespEnable,
  input logic             intDisable,
  input logic             intPending,
  input logic             wrEn,
  input logic [REG_W-1:0] wrData,
  input logic [REG_W-1:0] rdData,
  input logic             intxN
);
  p_const_fields_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & 16'h06F7) == 16'h0210);

  p_parity_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    parityErrEvt |=> rdData[15]);

  p_sys_gated_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdData[14]) |-> $past(sysErrEvt && serrEnable));

  p_dpar_gated_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdData[8]) |-> $past(perrSeen && busMasterActive && parityRespEnable));

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (masterAbortEvt && wrEn && wrData[13]) |=> rdData[13]);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[11] && !targetAbortSigEvt) |=> !rdData[11]);

  p_int_follow_r9: assert property (@(posedge clk) disable iff (!rstN)
    intPending |=> rdData[3]);

  p_intx_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    intDisable |-> intxN);

  p_intx_src_r10: assert property (@(posedge clk) disable iff (!rstN)
    !intxN |-> rdData[3]);
endmodule

bind pci_cfg_status pci_cfg_status_chk u_chk (.*);

// File: tb/test_pci_cfg_status.sv
module test_pci_cfg_status;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic parityErrEvt = 0, sysErrEvt = 0, serrEnable = 0, masterAbortEvt = 0;
  logic targetAbortRcvEvt = 0, targetAbortSigEvt = 0, perrSeen = 0;
  logic busMasterActive = 0, parityRespEnable = 0, intDisable = 0, intPending = 0;
  logic wrEn = 0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic intxN;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pci_cfg_status i_pci_cfg_status (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idleInputs();
    parityErrEvt = 0; sysErrEvt = 0; masterAbortEvt = 0;
    targetAbortRcvEvt = 0; targetAbortSigEvt = 0; perrSeen = 0;
    busMasterActive = 0; parityRespEnable = 0; serrEnable = 0;
    wrEn = 0; wrData = '0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clearAll();
    wrEn = 1; wrData = 16'hFFFF; tick(); idleInputs();
  endtask

  // sticky index -> bit position, same mapping as stated in R4/R5
  function automatic int posOf(input int i);
    return (i == 0) ? 8 : 10 + i;
  endfunction

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [15:0] exp;
    logic [15:0] mask;
    tick();
    check("R1 reset", rdData, 16'h0210);
    check("R1 intx", {15'd0, intxN}, 16'd1);
    tick(); rstN = 1; tick();
    check("R1 after release", rdData, 16'h0210);

    // R2 parity
    parityErrEvt = 1; tick(); idleInputs();
    check("R2 parity", rdData, 16'h8210);
    clearAll();

    // R3 system error gated by enable: all four combinations
    for (int c = 0; c < 4; c++) begin
      sysErrEvt = c[0]; serrEnable = c[1]; tick(); idleInputs();
      exp = 16'h0210 | ((c == 3) ? 16'h4000 : 16'h0);
      check("R3 sys err gating", rdData, exp);
      clearAll();
    end

    // R4 each abort alone
    masterAbortEvt = 1; tick(); idleInputs();
    check("R4 master abort", rdData, 16'h2210); clearAll();
    targetAbortRcvEvt = 1; tick(); idleInputs();
    check("R4 target abort rcv", rdData, 16'h1210); clearAll();
    targetAbortSigEvt = 1; tick(); idleInputs();
    check("R4 target abort sig", rdData, 16'h0A10); clearAll();

    // R5 data parity: all eight qualifier combinations
    for (int c = 0; c < 8; c++) begin
      perrSeen = c[0]; busMasterActive = c[1]; parityRespEnable = c[2];
      tick(); idleInputs();
      exp = 16'h0210 | ((c == 7) ? 16'h0100 : 16'h0);
      check("R5 data parity gating", rdData, exp);
      clearAll();
    end

    // R6 write-1-to-clear sweep over all sticky masks
    for (int p = 0; p < 64; p++) begin
      parityErrEvt = 1; sysErrEvt = 1; serrEnable = 1; masterAbortEvt = 1;
      targetAbortRcvEvt = 1; targetAbortSigEvt = 1;
      perrSeen = 1; busMasterActive = 1; parityRespEnable = 1;
      tick(); idleInputs();
      mask = '0;
      exp = 16'h0210;
      for (int i = 0; i < 6; i++) begin
        if (p[i]) mask[posOf(i)] = 1'b1;
        else      exp[posOf(i)]  = 1'b1;
      end
      wrEn = 1; wrData = mask; tick(); idleInputs();
      check("R6 w1c mask", rdData, exp);
      tick();
      check("R6 zero write holds", rdData, exp);
      clearAll();
    end

    // R7 set wins over clear
    masterAbortEvt = 1; wrEn = 1; wrData = 16'hFFFF; tick(); idleInputs();
    check("R7 set wins", rdData, 16'h2210);
    clearAll();

    // R8 read-only fields after FFFFh write
    wrEn = 1; wrData = 16'hFFFF; tick(); idleInputs();
    check("R8 read-only fields", rdData, 16'h0210);

    // R9 / R10 interrupt status and INTx over pending/disable
    for (int c = 0; c < 4; c++) begin
      intPending = c[0]; intDisable = c[1]; tick();
      check("R9 int status", rdData, 16'h0210 | (c[0] ? 16'h0008 : 16'h0));
      check("R10 intx", {15'd0, intxN}, (c == 1) ? 16'd0 : 16'd1);
    end
    intPending = 0; intDisable = 0; tick();
    check("R9 int drops", rdData, 16'h0210);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule